// File: doc/BRIEF.md
# Four-Channel Register-Programmed PWM Generator

This block turns one input clock into four independent pulse-width-modulated outputs. Software programs it through a small word-addressed register window carried on a valid/ready request bus. Each read request returns its data one cycle after acceptance. Channels 0 and 1 share one 8-bit prescaler, and channels 2 and 3 share a second one. After its pair's prescaler, each channel has its own power-of-two divider chosen by a 3-bit select code. The divided clock drives a per-channel down-counter. Its reload value sets the period, and a compare value sets how long the output stays active in each period.

A channel runs only while both its enable bit and its continuous-mode bit are set. A stopped channel drives its inactive level. An invert bit flips the pin in every state. New period and compare values are copied into the running counter only when it wraps, so a write never produces a shortened period. The live count of each channel can be read back, but not written.

Top module: `quad_pwm_ctrl`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Register map (byte offsets, word-aligned): prescale 0x00, clock select 0x04, control 0x08. For each channel n, period is at 0x0C+12n and compare at 0x10+12n. Readback keeps prescale bits 15:0, clock select bits 15:0, control bits 19:0, and period and compare bits 15:0; all other bits read zero. A misaligned access (address bits 1:0 not zero) writes nothing and reads zero. Any other offset, including 0x3C to 0x50, reads zero and ignores writes.
- R3: Offset 0x14+12n returns channel n's live down-count, which is zero while the channel is stopped. Writes to that offset are ignored.
- R4: Prescale bits 7:0 (value p) serve channels 0 and 1, and bits 15:8 serve channels 2 and 3. The prescaler divides the input clock by p+1.
- R5: Channel n's clock select code sits in bits 4n+2:4n. Codes 0 to 3 divide the prescaled clock by 2, 4, 8 and 16. Code 4 and every code above it pass the prescaled clock through undivided.
- R6: Channel n's 4-bit control field starts at bit 0, 8, 12 or 16 for n = 0 to 3. Within the field, bit 0 is enable, bit 2 is invert and bit 3 is continuous mode. The channel runs only when enable and continuous mode are both set; otherwise it drives the inactive level.
- R7: With tick length T input cycles, a running channel has a period of (period+1)·T cycles. Its output is active for (compare+1)·T of those cycles.
- R8: A compare value at or above a non-zero period keeps the output active all the time. A period of zero keeps it inactive all the time.
- R9: Invert complements the pin in every state, so a stopped or 0%-duty channel drives high when inverted.
- R10: Period and compare writes take effect only at the next reload, when the count wraps from zero. A write accepted on the reload edge itself takes effect one period later.
- R11: The request side is always ready. Every accepted request gives rsp_valid high exactly one cycle later, and idle cycles give it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after a request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
A bus write to a period register and that channel's counter reload can fall on the same clock edge. The bench runs a channel with a one-cycle tick. It predicts the reload edge from the observed falling edges of the output. It then lands one period write on that edge and another one cycle before it. The outcome is judged from the measured fall-to-fall intervals: the write one cycle early must change the very next period, and the write on the edge must leave one more period at the old length.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

  localparam int PRE_FW = 8;   // prescale field width per pair
  localparam int SEL_FW = 3;   // clock select code width
  localparam int CTL_FW = 4;   // control field width
  localparam int DIV_W  = 4;   // divider counter width (max divide 16)

  // control field layout, bit 0 lowest
  typedef struct packed {
    logic toggle;
    logic invert;
    logic spare;
    logic enable;
  } chctl_t;

  // lsb of the control field of a channel
  function automatic int ctl_lsb(int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  // lsb of the clock select code of a channel
  function automatic int sel_lsb(int ch);
    return 4 * ch;
  endfunction

  // terminal value of the divider counter for a select code
  function automatic logic [DIV_W-1:0] div_limit(logic [SEL_FW-1:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd3;
      3'd2:    return 4'd7;
      3'd3:    return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 16,
  parameter int SEL_W  = 16,
  parameter int CTL_W  = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [NCH-1:0][CNT_W-1:0]  live_cnt,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [PRE_W-1:0]           pre_q,
  output logic [SEL_W-1:0]           sel_q,
  output logic [CTL_W-1:0]           ctl_q,
  output logic [NCH-1:0][CNT_W-1:0]  per_q,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_q
);

  localparam int WORD_W = ADDR_W - 2;

  logic              aligned;
  logic              wr_hit;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_word;

  assign aligned = (req_addr[1:0] == 2'b00);
  assign wr_hit  = req_valid & req_write & aligned;
  assign word    = req_addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      sel_q <= '0;
      ctl_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
    end else if (wr_hit) begin
      if (word == WORD_W'(0)) pre_q <= req_wdata[PRE_W-1:0];
      if (word == WORD_W'(1)) sel_q <= req_wdata[SEL_W-1:0];
      if (word == WORD_W'(2)) ctl_q <= req_wdata[CTL_W-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (word == WORD_W'(3 + 3 * n)) per_q[n] <= req_wdata[CNT_W-1:0];
        if (word == WORD_W'(4 + 3 * n)) cmp_q[n] <= req_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (word == WORD_W'(0)) rd_word = DATA_W'(pre_q);
      if (word == WORD_W'(1)) rd_word = DATA_W'(sel_q);
      if (word == WORD_W'(2)) rd_word = DATA_W'(ctl_q);
      for (int n = 0; n < NCH; n++) begin
        if (word == WORD_W'(3 + 3 * n)) rd_word = DATA_W'(per_q[n]);
        if (word == WORD_W'(4 + 3 * n)) rd_word = DATA_W'(cmp_q[n]);
        if (word == WORD_W'(5 + 3 * n)) rd_word = DATA_W'(live_cnt[n]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/qpwm_tickgen.sv
module qpwm_tickgen
  import qpwm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NPAIR = 2,
  parameter int PRE_W = 16,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_cfg,
  input  logic [SEL_W-1:0] sel_cfg,
  output logic [NPAIR-1:0] pre_tick,
  output logic [NCH-1:0]   ch_tick
);

  // one prescaler per channel pair
  for (genvar p = 0; p < NPAIR; p++) begin : g_pre
    logic [PRE_FW-1:0] pcnt;
    logic [PRE_FW-1:0] plim;

    assign plim        = pre_cfg[p*PRE_FW +: PRE_FW];
    assign pre_tick[p] = (pcnt >= plim);

    always_ff @(posedge clk) begin
      if (!rst_n)           pcnt <= '0;
      else if (pre_tick[p]) pcnt <= '0;
      else                  pcnt <= pcnt + PRE_FW'(1);
    end
  end

  // one power-of-two divider per channel
  for (genvar c = 0; c < NCH; c++) begin : g_div
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] dlim;
    logic             dwrap;

    assign dlim       = div_limit(sel_cfg[sel_lsb(c) +: SEL_FW]);
    assign dwrap      = (dcnt >= dlim);
    assign ch_tick[c] = pre_tick[c/2] & dwrap;

    always_ff @(posedge clk) begin
      if (!rst_n)             dcnt <= '0;
      else if (pre_tick[c/2]) dcnt <= dwrap ? '0 : dcnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  chctl_t           ctl,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] compare,
  output logic             pwm,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cur_per,
  output logic [CNT_W-1:0] cur_cmp,
  output logic             running,
  output logic             reload
);

  // whether the waveform is in its active part for a given count
  function automatic logic in_active(logic [CNT_W-1:0] c,
                                     logic [CNT_W-1:0] per,
                                     logic [CNT_W-1:0] cmp);
    if (per == '0)  return 1'b0;
    if (cmp >= per) return 1'b1;
    return (c <= cmp);
  endfunction

  logic active;

  assign running = ctl.enable & ctl.toggle;
  assign reload  = running & tick & (cnt == '0);
  assign active  = running & in_active(cnt, cur_per, cur_cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_per <= '0;
      cur_cmp <= '0;
    end else if (!running) begin
      cnt     <= '0;
      cur_per <= period;
      cur_cmp <= compare;
    end else if (reload) begin
      cnt     <= period;
      cur_per <= period;
      cur_cmp <= compare;
    end else if (tick) begin
      cnt     <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= active ^ ctl.invert;
  end

endmodule

// File: rtl/quad_pwm_ctrl.sv
module quad_pwm_ctrl
  import qpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int NPAIR = (NCH + 1) / 2;
  localparam int PRE_W = PRE_FW * NPAIR;
  localparam int SEL_W = 4 * NCH;
  localparam int CTL_W = ctl_lsb(NCH - 1) + CTL_FW;

  logic [PRE_W-1:0]          pre_cfg;
  logic [SEL_W-1:0]          sel_cfg;
  logic [CTL_W-1:0]          ctl_cfg;
  logic [NCH-1:0][CNT_W-1:0] per_cfg;
  logic [NCH-1:0][CNT_W-1:0] cmp_cfg;
  logic [NCH-1:0][CNT_W-1:0] ch_cnt;
  logic [NCH-1:0][CNT_W-1:0] ch_cur_per;
  logic [NCH-1:0][CNT_W-1:0] ch_cur_cmp;
  logic [NCH-1:0]            ch_run;
  logic [NCH-1:0]            ch_inv;
  logic [NCH-1:0]            ch_reload;
  logic [NCH-1:0]            ch_tick;
  logic [NPAIR-1:0]          pre_tick;

  assign req_ready = 1'b1;

  qpwm_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRE_W(PRE_W), .SEL_W(SEL_W), .CTL_W(CTL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .live_cnt  (ch_cnt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pre_q     (pre_cfg),
    .sel_q     (sel_cfg),
    .ctl_q     (ctl_cfg),
    .per_q     (per_cfg),
    .cmp_q     (cmp_cfg)
  );

  qpwm_tickgen #(
    .NCH(NCH), .NPAIR(NPAIR), .PRE_W(PRE_W), .SEL_W(SEL_W)
  ) u_ticks (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_cfg  (pre_cfg),
    .sel_cfg  (sel_cfg),
    .pre_tick (pre_tick),
    .ch_tick  (ch_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chctl_t ctl_i;
    assign ctl_i     = chctl_t'(ctl_cfg[ctl_lsb(i) +: CTL_FW]);
    assign ch_inv[i] = ctl_i.invert;

    qpwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ch_tick[i]),
      .ctl     (ctl_i),
      .period  (per_cfg[i]),
      .compare (cmp_cfg[i]),
      .pwm     (pwm_out[i]),
      .cnt     (ch_cnt[i]),
      .cur_per (ch_cur_per[i]),
      .cur_cmp (ch_cur_cmp[i]),
      .running (ch_run[i]),
      .reload  (ch_reload[i])
    );
  end

endmodule

// File: rtl/qpwm_checker.sv
module qpwm_checker #(
  parameter int NCH   = 4,
  parameter int NPAIR = 2,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            ch_run,
  input logic [NCH-1:0]            ch_inv,
  input logic [NCH-1:0]            ch_reload,
  input logic [NCH-1:0]            ch_tick,
  input logic [NPAIR-1:0]          pre_tick,
  input logic [NCH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NCH-1:0][CNT_W-1:0] ch_cur_per,
  input logic [NCH-1:0][CNT_W-1:0] ch_cur_cmp
);

  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r11_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[i] |=> (pwm_out[i] == $past(ch_inv[i])));

    a_r8_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && ch_cur_per[i] != '0 && ch_cur_cmp[i] >= ch_cur_per[i])
      |=> (pwm_out[i] == !$past(ch_inv[i])));

    a_r8_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && ch_cur_per[i] == '0) |=> (pwm_out[i] == $past(ch_inv[i])));

    a_r10_latch_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && $past(ch_run[i]) && ch_cur_per[i] != $past(ch_cur_per[i]))
      |-> $past(ch_reload[i]));

    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cnt[i] <= ch_cur_per[i]);

    a_r5_tick_needs_prescale: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> pre_tick[i/2]);
  end

endmodule

bind quad_pwm_ctrl qpwm_checker #(.NCH(NCH), .NPAIR(NPAIR), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .pwm_out    (pwm_out),
  .ch_run     (ch_run),
  .ch_inv     (ch_inv),
  .ch_reload  (ch_reload),
  .ch_tick    (ch_tick),
  .pre_tick   (pre_tick),
  .ch_cnt     (ch_cnt),
  .ch_cur_per (ch_cur_per),
  .ch_cur_cmp (ch_cur_cmp)
);

// File: tb/test_quad_pwm_ctrl.sv
module test_quad_pwm_ctrl;

  localparam int NCH    = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NCH-1:0]    pwm_out;

  always #10 clk = ~clk;  // 50 MHz

  quad_pwm_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_quad_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  int errors = 0;
  int checks = 0;

  // ---- falling-edge monitor on one selected channel ----
  int   cyc = 0;
  int   mon_ch = 0;
  logic mon_pol = 1'b0;
  int   nf = 0;
  int   fall_at [64];
  int   hi_in   [64];
  int   hi_acc = 0;
  logic mon_prev = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    logic v;
    v = pwm_out[mon_ch] ^ mon_pol;
    if (v) hi_acc++;
    if (mon_prev && !v) begin
      fall_at[nf % 64] = cyc;
      hi_in[nf % 64]   = hi_acc;
      hi_acc = 0;
      nf++;
    end
    mon_prev = v;
  end

  // ---- helpers ----
  function automatic int per_ofs(int c); return 12 + 12 * c; endfunction
  function automatic int cmp_ofs(int c); return 16 + 12 * c; endfunction
  function automatic int cnt_ofs(int c); return 20 + 12 * c; endfunction
  function automatic int ctl_pos(int c); return (c == 0) ? 0 : 4 * c + 4; endfunction
  function automatic int tick_len(int pre, int code);
    return (pre + 1) * ((code < 4) ? (2 << code) : 1);
  endfunction
  function automatic int run_word(int c, int inv);
    return (1 + 4 * inv + 8) << ctl_pos(c);
  endfunction

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(int a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr  = ADDR_W'(a); req_wdata = d;
    @(negedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R11 read response valid", rsp_valid, 1);
    d = rsp_rdata;
  endtask

  task automatic wait_falls(int target);
    int n;
    n = 0;
    while (nf < target && n < 20000) begin
      @(negedge clk); #1; n++;
    end
    if (nf < target) chk("R7 waveform edge timeout", nf, target);
  endtask

  function automatic int gap(int k);
    return fall_at[k % 64] - fall_at[(k - 1) % 64];
  endfunction

  task automatic steady(int c, logic exp, string what);
    int bad;
    bad = 0;
    idle(40);
    repeat (60) begin
      if (pwm_out[c] !== exp) bad++;
      @(negedge clk); #1;
    end
    chk(what, bad, 0);
  endtask

  task automatic run_tests();
    logic [31:0] d;
    int k;
    int unsigned seed;

    // ---- R1 reset state ----
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 outputs low after reset", pwm_out, 0);
    for (int a = 0; a <= 'h50; a += 4) begin
      rd(a, d);
      chk($sformatf("R1 reset value at 0x%0h", a), d, 0);
    end

    // ---- R2 readback, truncation, misaligned and unmapped ----
    wr('h00, 32'h00FF_A5C3);
    rd('h00, d); chk("R2 prescale readback", d, 32'hA5C3);
    wr('h04, 32'hFFFF_7777);
    rd('h04, d); chk("R2 clock select readback", d, 32'h7777);
    wr('h08, 32'h0004_4404);
    rd('h08, d); chk("R2 control readback", d, 32'h44404);
    idle(3);
    chk("R9 stopped inverted channels drive high", pwm_out, 4'b1111);
    wr('h08, 0);
    idle(3);
    chk("R9 stopped plain channels drive low", pwm_out, 0);
    wr(per_ofs(2), 32'hABCD_1234);
    rd(per_ofs(2), d); chk("R2 period keeps 16 bits", d, 32'h1234);
    wr(cmp_ofs(3), 32'h0001_0055);
    rd(cmp_ofs(3), d); chk("R2 compare keeps 16 bits", d, 32'h55);
    wr('h01, 32'hFF);
    rd('h00, d); chk("R2 misaligned write ignored", d, 32'hA5C3);
    rd('h02, d); chk("R2 misaligned read is zero", d, 0);
    wr('h3C, 32'hFFFF_FFFF);
    rd('h3C, d); chk("R2 unmapped offset 0x3C reads zero", d, 0);
    rd('h60, d); chk("R2 unmapped offset 0x60 reads zero", d, 0);
    rd(cnt_ofs(1), d); chk("R3 stopped channel count is zero", d, 0);

    // ---- R6 enable-only and toggle-only do not run ----
    wr('h00, 0); wr('h04, 32'h4444);
    wr(per_ofs(1), 3); wr(cmp_ofs(1), 1);
    wr('h08, 32'h100);
    steady(1, 1'b0, "R6 enable without continuous mode stays idle");
    wr('h08, 32'h800);
    steady(1, 1'b0, "R6 continuous mode without enable stays idle");

    // ---- R7/R10 directed on channel 0 with a one-cycle tick ----
    wr('h08, 0);
    wr('h04, 32'h0004);
    wr(per_ofs(0), 20); wr(cmp_ofs(0), 5);
    mon_ch = 0; mon_pol = 1'b0;
    wr('h08, run_word(0, 0));
    wait_falls(nf + 3);
    k = nf - 1;
    chk("R7 period of 21 ticks", gap(k), 21);
    chk("R7 active time of 6 ticks", hi_in[k % 64], 6);
    rd(cnt_ofs(0), d);
    chk("R3 live count within period", (d <= 20) ? 1 : 0, 1);
    wr(cnt_ofs(0), 32'hFFFF);
    wait_falls(nf + 2);
    k = nf - 1;
    chk("R3 count write leaves period unchanged", gap(k), 21);

    // write one cycle before the reload edge: next period changes
    wait_falls(nf + 1);
    k = nf - 1;
    idle(20 - 2);
    wr(per_ofs(0), 12);
    wait_falls(k + 3);
    chk("R10 period in progress keeps old length", gap(k + 1), 21);
    chk("R10 early write applies at next reload", gap(k + 2), 13);
    chk("R10 compare unchanged in new period", hi_in[(k + 2) % 64], 6);

    // write on the reload edge itself: one more old period
    wait_falls(nf + 1);
    k = nf - 1;
    idle(12 - 1);
    wr(per_ofs(0), 20);
    wait_falls(k + 4);
    chk("R10 in-progress period on same-edge write", gap(k + 1), 13);
    chk("R10 same-edge write misses that reload", gap(k + 2), 13);
    chk("R10 same-edge write applies one period later", gap(k + 3), 21);

    // ---- R8 zero period and full duty ----
    wr(per_ofs(0), 0);
    steady(0, 1'b0, "R8 zero period stays inactive");
    wr('h08, run_word(0, 1));
    steady(0, 1'b1, "R9 zero period inverted stays high");
    wr('h08, run_word(0, 0));
    wr(per_ofs(0), 5); wr(cmp_ofs(0), 5);
    steady(0, 1'b1, "R8 compare equal to period is full duty");
    wr(cmp_ofs(0), 9);
    steady(0, 1'b1, "R8 compare above period is full duty");

    // ---- R4/R5/R6/R7/R9 constrained random ----
    seed = $urandom(32'd2718);
    for (int it = 0; it < 14; it++) begin
      int c, p0, p1, cnr, cmp, inv, t;
      int code [4];
      logic [31:0] selw;
      c    = $urandom % 4;
      p0   = $urandom % 4;
      p1   = $urandom % 4;
      selw = 0;
      for (int j = 0; j < 4; j++) begin
        code[j] = $urandom % 8;
        selw |= 32'(code[j]) << (4 * j);
      end
      cnr = 1 + $urandom % 8;
      cmp = $urandom % cnr;
      inv = $urandom % 2;
      wr('h08, 0);
      wr('h00, 32'((p1 << 8) | p0));
      wr('h04, selw);
      wr(per_ofs(c), 32'(cnr));
      wr(cmp_ofs(c), 32'(cmp));
      mon_ch = c; mon_pol = inv[0];
      wr('h08, 32'(run_word(c, inv)));
      wait_falls(nf + 3);
      k = nf - 1;
      t = tick_len((c < 2) ? p0 : p1, code[c]);
      chk($sformatf("R4 R5 R6 ch%0d period (pre %0d/%0d code %0d)", c, p0, p1, code[c]),
          gap(k), (cnr + 1) * t);
      chk($sformatf("R7 R9 ch%0d active time inv=%0d", c, inv),
          hi_in[k % 64], (cmp + 1) * t);
    end
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule